// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program counter for a core whose instructions are all 16 bits long and whose branch instructions mostly take effect one instruction late. Each cycle a decoder reports what the instruction at the current address is: its branch class, whether its condition is met, its target address, and whether it may legally sit behind a delayed branch. From these inputs the block works out the address of the next instruction. It raises a flag while the current instruction occupies a delay slot. It requests a slot-illegal exception when a forbidden instruction turns up in that slot.

The control is a two-state machine. `ST_SEQ` is ordinary flow. `ST_SLOT` means the current instruction is a delay slot and a redirect address is held pending. The machine moves from `ST_SEQ` to `ST_SLOT` when a delayed branch, a delayed return or a delayed conditional completes. It moves from `ST_SLOT` to `ST_SEQ` when the slot instruction completes, and the held address is then applied. It enters `ST_SEQ` from either state on reset or exception entry. A stall holds the machine in whatever state it is in.

Top module: `dlyb_pc_seq`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) loads `pc` with parameter `RESET_VEC`, clears `in_slot` and leaves no redirect pending.
- R2: An instruction of class 0 (no branch, and also the unused codes 5 to 7) completing outside a slot is followed by `pc + 2`.
- R3: Class 3 (conditional, not delayed) is followed by `br_target` when `cond_met` is 1 and by `pc + 2` when it is 0, with no slot instruction in either case.
- R4: Class 1 (delayed unconditional) is followed by `pc + 2`, which is flagged by `in_slot`. After that slot instruction, `br_target` of the branch executes.
- R5: Class 2 (delayed return from exception) behaves in the same way as class 1: one slot instruction, then the recorded target.
- R6: Class 4 (delayed conditional) with `cond_met` 1 is followed by one slot instruction and then by `br_target`.
- R7: Class 4 with `cond_met` 0 still marks its follower as a slot. After the slot, execution continues at the branch address plus 4.
- R8: When an instruction completes in a slot with `slot_forbid` 1, `slot_illegal` is 1 for that one cycle, and the pending target is still applied.
- R9: A branch of any class 1 to 4 completing in a slot raises `slot_illegal` for that one cycle. Its own redirect is discarded, and the pending target is applied.
- R10: `exc_take` sends `exc_vector` to the next `pc`, clears the slot state and pending target, and suppresses `slot_illegal`. It takes priority over `stall`.
- R11: While `stall` is 1 and `exc_take` is 0, `pc`, `in_slot` and the pending target hold, and `slot_illegal` stays 0.
- R12: `next_pc` shows, in the same cycle, the value that `pc` takes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the sequencer this cycle |
| exc_take | input | 1 | Exception entry this cycle |
| exc_vector | input | AW | Handler address for exception entry |
| br_class | input | 3 | Branch class of current instruction (0 none, 1 delayed jump, 2 delayed return, 3 conditional, 4 delayed conditional) |
| cond_met | input | 1 | Branch condition satisfied |
| br_target | input | AW | Branch target of current instruction |
| slot_forbid | input | 1 | Current instruction is not allowed in a delay slot |
| pc | output | AW | Address of the instruction now executing |
| next_pc | output | AW | Address of the instruction that follows |
| in_slot | output | 1 | Current instruction is a delay-slot instruction |
| slot_illegal | output | 1 | Slot-illegal exception request |

## Verification
A wrong state bit shows up at the ports in the same cycle. `in_slot` then disagrees with the instruction history, and `next_pc` points at the pending target when it should point at `pc + 2`, or the other way round. A corrupted pending register shows up one instruction later, when the slot completes and `pc` lands on the wrong address. The bench therefore compares `next_pc`, `in_slot` and `slot_illegal` before every edge, and compares `pc` after every edge, so any such fault is caught within two instructions.

// File: rtl/dlyb_pkg.sv
package dlyb_pkg;

    typedef enum logic [2:0] {
        BR_NONE     = 3'd0,
        BR_DLY_JUMP = 3'd1,
        BR_DLY_RTE  = 3'd2,
        BR_COND_NOW = 3'd3,
        BR_COND_DLY = 3'd4
    } br_class_e;

    typedef enum logic {
        ST_SEQ  = 1'b0,
        ST_SLOT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dlyb_branch_resolve.sv
module dlyb_branch_resolve
    import dlyb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    br_class,
    input  logic          cond_met,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] seq_pc,
    output logic          is_branch,
    output logic          jump_now,
    output logic          opens_slot,
    output logic [AW-1:0] slot_dest
);

    localparam logic [AW-1:0] STEP      = AW'(2);
    localparam logic [AW-1:0] SKIP_SLOT = AW'(4);

    br_class_e cls;

    assign cls    = br_class_e'(br_class);
    assign seq_pc = pc + STEP;

    always_comb begin
        is_branch  = 1'b0;
        jump_now   = 1'b0;
        opens_slot = 1'b0;
        slot_dest  = br_target;
        case (cls)
            BR_DLY_JUMP, BR_DLY_RTE: begin
                is_branch  = 1'b1;
                opens_slot = 1'b1;
            end
            BR_COND_NOW: begin
                is_branch = 1'b1;
                jump_now  = cond_met;
            end
            BR_COND_DLY: begin
                is_branch  = 1'b1;
                opens_slot = 1'b1;
                slot_dest  = cond_met ? br_target : (pc + SKIP_SLOT);
            end
            default: begin
                is_branch = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dlyb_seq_fsm.sv
module dlyb_seq_fsm
    import dlyb_pkg::*;
#(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          exc_take,
    input  logic [AW-1:0] exc_vector,
    input  logic [AW-1:0] seq_pc,
    input  logic          is_branch,
    input  logic          jump_now,
    input  logic [AW-1:0] jump_addr,
    input  logic          opens_slot,
    input  logic [AW-1:0] slot_dest,
    input  logic          slot_forbid,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] next_pc,
    output logic          in_slot,
    output logic          slot_illegal
);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            pc_q    <= RESET_VEC;
            pend_q  <= RESET_VEC;
        end else begin
            state_q <= state_d;
            pc_q    <= next_pc;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        pend_d       = pend_q;
        next_pc      = pc_q;
        slot_illegal = 1'b0;
        if (exc_take) begin
            next_pc = exc_vector;
            state_d = ST_SEQ;
            pend_d  = exc_vector;
        end else if (!stall) begin
            unique case (state_q)
                ST_SEQ: begin
                    next_pc = jump_now ? jump_addr : seq_pc;
                    if (opens_slot) begin
                        state_d = ST_SLOT;
                        pend_d  = slot_dest;
                    end
                end
                ST_SLOT: begin
                    slot_illegal = slot_forbid | is_branch;
                    next_pc      = pend_q;
                    state_d      = ST_SEQ;
                end
            endcase
        end
    end

    assign pc      = pc_q;
    assign in_slot = (state_q == ST_SLOT);

endmodule

// File: rtl/dlyb_pc_seq.sv
module dlyb_pc_seq #(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RESET_VEC = 32'hA000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          exc_take,
    input  logic [AW-1:0] exc_vector,
    input  logic [2:0]    br_class,
    input  logic          cond_met,
    input  logic [AW-1:0] br_target,
    input  logic          slot_forbid,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] next_pc,
    output logic          in_slot,
    output logic          slot_illegal
);

    logic [AW-1:0] seq_pc;
    logic          is_branch;
    logic          jump_now;
    logic          opens_slot;
    logic [AW-1:0] slot_dest;

    dlyb_branch_resolve #(.AW(AW)) u_resolve (
        .br_class   (br_class),
        .cond_met   (cond_met),
        .pc         (pc),
        .br_target  (br_target),
        .seq_pc     (seq_pc),
        .is_branch  (is_branch),
        .jump_now   (jump_now),
        .opens_slot (opens_slot),
        .slot_dest  (slot_dest)
    );

    dlyb_seq_fsm #(.AW(AW), .RESET_VEC(RESET_VEC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .exc_take     (exc_take),
        .exc_vector   (exc_vector),
        .seq_pc       (seq_pc),
        .is_branch    (is_branch),
        .jump_now     (jump_now),
        .jump_addr    (br_target),
        .opens_slot   (opens_slot),
        .slot_dest    (slot_dest),
        .slot_forbid  (slot_forbid),
        .pc           (pc),
        .next_pc      (next_pc),
        .in_slot      (in_slot),
        .slot_illegal (slot_illegal)
    );

endmodule

// File: rtl/dlyb_pc_seq_chk.sv
module dlyb_pc_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          exc_take,
    input logic [AW-1:0] exc_vector,
    input logic [2:0]    br_class,
    input logic          cond_met,
    input logic [AW-1:0] br_target,
    input logic          slot_forbid,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] next_pc,
    input logic          in_slot,
    input logic          slot_illegal
);

    logic run;
    assign run = !stall && !exc_take;

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_slot && br_class == 3'd0) |=> (pc == $past(pc) + AW'(2)) && !in_slot);

    assert_cond_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_slot && br_class == 3'd3 && cond_met) |=> (pc == $past(br_target)) && !in_slot);

    assert_dly_jump_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_slot && br_class == 3'd1) |=> in_slot && (pc == $past(pc) + AW'(2)));

    assert_rte_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_slot && br_class == 3'd2) |=> in_slot);

    assert_dly_cond_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !in_slot && br_class == 3'd4) |=> in_slot);

    assert_illegal_only_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_illegal |-> in_slot && run);

    assert_illegal_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_illegal |=> !slot_illegal && !in_slot);

    assert_exc_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (pc == $past(exc_vector)) && !in_slot);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !exc_take) |=> $stable(pc) && $stable(in_slot));

    assert_lookahead_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pc == $past(next_pc));

endmodule

bind dlyb_pc_seq dlyb_pc_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .exc_take     (exc_take),
    .exc_vector   (exc_vector),
    .br_class     (br_class),
    .cond_met     (cond_met),
    .br_target    (br_target),
    .slot_forbid  (slot_forbid),
    .pc           (pc),
    .next_pc      (next_pc),
    .in_slot      (in_slot),
    .slot_illegal (slot_illegal)
);

// File: tb/dlyb_pc_seq_tb.sv
module dlyb_pc_seq_tb;

    localparam int          AW  = 32;
    localparam logic [31:0] RV  = 32'hA000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          exc_take = 1'b0;
    logic [AW-1:0] exc_vector = '0;
    logic [2:0]    br_class = 3'd0;
    logic          cond_met = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          slot_forbid = 1'b0;
    logic [AW-1:0] pc, next_pc;
    logic          in_slot, slot_illegal;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [AW-1:0] pc;
        logic          slot;
        string         req;
    } exp_t;

    exp_t q[$];

    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_pend;
    logic          m_slot;

    dlyb_pc_seq #(.AW(AW), .RESET_VEC(RV)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .exc_take(exc_take),
        .exc_vector(exc_vector), .br_class(br_class), .cond_met(cond_met),
        .br_target(br_target), .slot_forbid(slot_forbid), .pc(pc),
        .next_pc(next_pc), .in_slot(in_slot), .slot_illegal(slot_illegal)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops the expected state after each clock edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "pc after edge", pc, e.pc);
            check(e.req, "in_slot after edge", AW'(in_slot), AW'(e.slot));
        end
    end

    // driver: applies one instruction at a falling edge, predicts, pushes
    task automatic step(input logic [2:0] cls, input logic cnd, input logic [AW-1:0] tgt,
                        input logic fbd, input logic stl, input logic exc,
                        input logic [AW-1:0] vec, input string req);
        logic [AW-1:0] npc;
        logic          nslot;
        logic [AW-1:0] npend;
        logic          ill;
        br_class = cls; cond_met = cnd; br_target = tgt; slot_forbid = fbd;
        stall = stl; exc_take = exc; exc_vector = vec;
        npc = m_pc; nslot = m_slot; npend = m_pend;
        ill = m_slot && !stl && !exc && (fbd || (cls >= 3'd1 && cls <= 3'd4));
        if (exc) begin
            npc = vec; nslot = 1'b0; npend = vec;
        end else if (!stl) begin
            if (m_slot) begin
                npc = m_pend; nslot = 1'b0;
            end else begin
                case (cls)
                    3'd1, 3'd2: begin npc = m_pc + 2; nslot = 1'b1; npend = tgt; end
                    3'd3:       npc = cnd ? tgt : m_pc + 2;
                    3'd4: begin npc = m_pc + 2; nslot = 1'b1; npend = cnd ? tgt : m_pc + 4; end
                    default:    npc = m_pc + 2;
                endcase
            end
        end
        #1;
        check(req, "in_slot before edge", AW'(in_slot), AW'(m_slot));
        check(req, "slot_illegal", AW'(slot_illegal), AW'(ill));
        check("R12", "next_pc lookahead", next_pc, npc);
        q.push_back('{pc: npc, slot: nslot, req: req});
        m_pc = npc; m_slot = nslot; m_pend = npend;
        @(negedge clk);
    endtask

    initial begin
        m_pc = RV; m_slot = 1'b0; m_pend = RV;
        repeat (2) @(negedge clk);
        check("R1", "reset pc", pc, RV);
        check("R1", "reset in_slot", AW'(in_slot), '0);
        rst_n = 1'b1;

        step(3'd0, 0, '0, 0, 0, 0, '0, "R2");
        step(3'd6, 0, 32'h1234, 0, 0, 0, '0, "R2");
        step(3'd3, 1, 32'hA000_0100, 0, 0, 0, '0, "R3");
        step(3'd3, 0, 32'hA000_0F00, 0, 0, 0, '0, "R3");
        step(3'd1, 0, 32'hA000_0200, 0, 0, 0, '0, "R4");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R4");
        step(3'd2, 0, 32'hA000_0300, 0, 0, 0, '0, "R5");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R5");
        step(3'd4, 1, 32'hA000_0400, 0, 0, 0, '0, "R6");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R6");
        step(3'd4, 0, 32'hA000_0E00, 0, 0, 0, '0, "R7");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R7");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R7");
        step(3'd1, 0, 32'hA000_0500, 0, 0, 0, '0, "R8");
        step(3'd0, 0, '0, 1, 0, 0, '0, "R8");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R8");
        step(3'd1, 0, 32'hA000_0600, 0, 0, 0, '0, "R9");
        step(3'd3, 1, 32'hA000_0700, 0, 0, 0, '0, "R9");
        step(3'd4, 1, 32'hA000_0720, 0, 0, 0, '0, "R9");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R9");
        step(3'd1, 0, 32'hA000_0800, 0, 0, 0, '0, "R11");
        step(3'd0, 0, '0, 1, 1, 0, '0, "R11");
        step(3'd3, 1, 32'hA000_0D00, 0, 1, 0, '0, "R11");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R11");
        step(3'd3, 1, 32'hA000_0D40, 0, 1, 0, '0, "R11");
        step(3'd1, 0, 32'hA000_0900, 0, 0, 0, '0, "R10");
        step(3'd1, 0, '0, 1, 0, 1, 32'hA000_0F00, "R10");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R10");
        step(3'd0, 0, '0, 0, 1, 1, 32'hA000_0F80, "R10");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R2");
        step(3'd2, 0, 32'hA000_0A00, 0, 0, 0, '0, "R5");

        rst_n = 1'b0;
        #1;
        check("R1", "mid-run reset pc", pc, RV);
        check("R1", "mid-run reset in_slot", AW'(in_slot), '0);
        m_pc = RV; m_slot = 1'b0; m_pend = RV;
        @(negedge clk);
        rst_n = 1'b1;
        step(3'd0, 0, '0, 0, 0, 0, '0, "R1");
        step(3'd0, 0, '0, 0, 0, 0, '0, "R2");
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule